// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This unit sits in front of a DSP data memory and hands out one memory address for every request pulse. A configuration load captures a base address, a starting pointer and a size exponent. After that, each request is served in one of four addressing modes, chosen per request:

- **Linear pointer:** the pointer advances by a signed step.
- **Circular buffer:** the offset wraps modulo a power-of-two length.
- **Bit-reversed:** gives the reordered index sequence that a radix-2 FFT needs at its input or output.
- **Direct:** issues an immediate address and places it in the pointer.

All wrapping is done in hardware. The program therefore never compares a pointer against the end of a buffer. Every address comes out of a register, so it appears one clock after the request that asked for it.

The size exponent serves two purposes. In circular mode it sets the buffer length to 2^size. In bit-reversed mode it sets how many low index bits are mirrored, clamped to a range of 3 to 8. In both modes the low `size` bits of the base are ignored, which aligns the base to the region.

Top module: `dag_addr_gen`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `addr_out` is 0 and `addr_vld` is 0.
- R2: `addr_vld` is 1 in exactly the cycles that follow a cycle in which `next` was 1 and `ld_en` was 0. Each such request yields exactly one address.
- R3: When `ld_en` is 1, the unit captures `ld_base`, `ld_ptr` and `ld_size`.
  - A `ld_size` above 8 is stored as 8.
  - A `next` in the same cycle is ignored: no address is issued and the pointer is not advanced.
- R4: Mode `2'b00` is linear. The issued address is the pointer, and the pointer then grows by the sign-extended 8-bit `step`.
- R5: Mode `2'b01` is circular. The address is (base with its low `size` bits cleared) plus (pointer mod 2^size), and the pointer then grows by `step`. With size 3 and step 1 from pointer 0, pointer values 8 and 16 give offset 0, and 15 and 23 give offset 7.
- R6: Mode `2'b10` is bit-reversed. Let k be `size` clamped to the range 3 to 8. The address is (base with its low k bits cleared) OR (the low k pointer bits in reversed order), and the pointer then grows by `step`. With k=3 and step 1 from pointer 0, the offsets are 0,4,2,6,1,5,3,7.
- R7: Mode `2'b11` is direct. The address is `ld_ptr` sampled with the request, and the pointer becomes that value.
- R8: In circular mode a negative step or a step larger than one still wraps inside the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load base, pointer and size |
| ld_base | input | 16 | Base address to load |
| ld_ptr | input | 16 | Pointer to load; immediate address in direct mode |
| ld_size | input | 4 | Size exponent to load (saturates at 8) |
| mode | input | 2 | 00 linear, 01 circular, 10 bit-reversed, 11 direct |
| step | input | 8 | Signed pointer increment |
| next | input | 1 | Request one address |
| addr_out | output | 16 | Registered address |
| addr_vld | output | 1 | Address on addr_out is new this cycle |

## Verification
Every address is due exactly one clock edge after its request, because the next-state logic feeds a single register stage. The driver task computes each expected address from a model of the requirements at the falling edge where it raises `next`, and pushes it into a queue. The monitor looks at `addr_vld` on the following falling edge. There it pops the queue and compares, so both the one-cycle latency and the address value are checked. A valid with an empty queue, or a queue that is still non-empty after the run, is reported as a missing or extra address. This covers the cases where a load hides a request.

// File: rtl/dag_pkg.sv
package dag_pkg;
    typedef enum logic [1:0] {
        MODE_LIN  = 2'b00,
        MODE_CIRC = 2'b01,
        MODE_BREV = 2'b10,
        MODE_DIR  = 2'b11
    } dag_mode_e;

    localparam int BREV_MIN_BITS = 3;
endpackage

// File: rtl/dag_mask.sv
// Thermometer mask: bit i set when i < size.
module dag_mask #(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 4
) (
    input  logic [SIZE_W-1:0] size,
    output logic [ADDR_W-1:0] mask
);
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign mask[i] = (32'(size) > i);
    end
endmodule

// File: rtl/dag_bitrev.sv
// Mirrors the low nbits of idx; higher result bits are zero.
module dag_bitrev #(
    parameter int IDX_W  = 8,
    parameter int SIZE_W = 4
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [SIZE_W-1:0] nbits,
    output logic [IDX_W-1:0]  rev
);
    logic [IDX_W-1:0] cand [0:IDX_W];

    for (genvar g = 0; g <= IDX_W; g++) begin : g_width
        for (genvar b = 0; b < IDX_W; b++) begin : g_bit
            if (b < g) begin : g_on
                assign cand[g][b] = idx[g-1-b];
            end else begin : g_off
                assign cand[g][b] = 1'b0;
            end
        end
    end

    always_comb begin
        if (32'(nbits) >= IDX_W) begin
            rev = cand[IDX_W];
        end else begin
            rev = cand[nbits];
        end
    end
endmodule

// File: rtl/dag_addr_gen.sv
module dag_addr_gen
    import dag_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int STEP_W   = 8,
    parameter int MAX_LOG2 = 8,
    parameter int SIZE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [ADDR_W-1:0] ld_ptr,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic [1:0]        mode,
    input  logic [STEP_W-1:0] step,
    input  logic              next,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_vld
);
    localparam logic [SIZE_W-1:0] SIZE_MAX = SIZE_W'(MAX_LOG2);
    localparam logic [SIZE_W-1:0] SIZE_MIN = SIZE_W'(BREV_MIN_BITS);
    localparam int PAD_W = ADDR_W - MAX_LOG2;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] ptr;
        logic [SIZE_W-1:0] size;
        logic [ADDR_W-1:0] addr;
        logic              vld;
    } agu_state_t;

    agu_state_t st_d, st_q;

    logic [ADDR_W-1:0]   circ_mask, brev_mask;
    logic [ADDR_W-1:0]   circ_base, circ_addr, brev_addr;
    logic [SIZE_W-1:0]   brev_size;
    logic [MAX_LOG2-1:0] rev_idx;
    logic [ADDR_W-1:0]   step_ext;

    assign brev_size = (st_q.size < SIZE_MIN) ? SIZE_MIN : st_q.size;
    assign step_ext  = ADDR_W'($signed(step));

    dag_mask #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_cmask (
        .size (st_q.size),
        .mask (circ_mask)
    );

    dag_mask #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_bmask (
        .size (brev_size),
        .mask (brev_mask)
    );

    dag_bitrev #(.IDX_W(MAX_LOG2), .SIZE_W(SIZE_W)) u_brev (
        .idx   (st_q.ptr[MAX_LOG2-1:0]),
        .nbits (brev_size),
        .rev   (rev_idx)
    );

    // Aligned base plus wrapped offset; no adder needed since base is aligned.
    assign circ_base = st_q.base & ~circ_mask;
    assign circ_addr = circ_base | (st_q.ptr & circ_mask);
    assign brev_addr = (st_q.base & ~brev_mask) | {{PAD_W{1'b0}}, rev_idx};

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (ld_en) begin
            st_d.base = ld_base;
            st_d.ptr  = ld_ptr;
            st_d.size = (ld_size > SIZE_MAX) ? SIZE_MAX : ld_size;
        end else if (next) begin
            st_d.vld = 1'b1;
            case (dag_mode_e'(mode))
                MODE_LIN: begin
                    st_d.addr = st_q.ptr;
                    st_d.ptr  = st_q.ptr + step_ext;
                end
                MODE_CIRC: begin
                    st_d.addr = circ_addr;
                    st_d.ptr  = st_q.ptr + step_ext;
                end
                MODE_BREV: begin
                    st_d.addr = brev_addr;
                    st_d.ptr  = st_q.ptr + step_ext;
                end
                default: begin
                    st_d.addr = ld_ptr;
                    st_d.ptr  = ld_ptr;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_out = st_q.addr;
    assign addr_vld = st_q.vld;
endmodule

// File: rtl/dag_addr_gen_chk.sv
module dag_addr_gen_chk
    import dag_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int STEP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_en,
    input logic [ADDR_W-1:0] ld_ptr,
    input logic [1:0]        mode,
    input logic [STEP_W-1:0] step,
    input logic              next,
    input logic [ADDR_W-1:0] addr_out,
    input logic              addr_vld,
    input logic [ADDR_W-1:0] circ_mask,
    input logic [ADDR_W-1:0] circ_base
);
    // R2
    req_to_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (next && !ld_en) |=> addr_vld);

    // R2
    no_req_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(next && !ld_en) |=> !addr_vld);

    // R4
    linear_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (next && !ld_en && mode == MODE_LIN
         && $past(next && !ld_en && mode == MODE_LIN))
        |=> addr_out == $past(addr_out) + ADDR_W'($signed($past(step, 2))));

    // R5
    circ_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (next && !ld_en && mode == MODE_CIRC)
        |=> (addr_out & ~$past(circ_mask)) == $past(circ_base));

    // R7
    direct_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (next && !ld_en && mode == MODE_DIR) |=> addr_out == $past(ld_ptr));
endmodule

bind dag_addr_gen dag_addr_gen_chk #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (ld_en),
    .ld_ptr    (ld_ptr),
    .mode      (mode),
    .step      (step),
    .next      (next),
    .addr_out  (addr_out),
    .addr_vld  (addr_vld),
    .circ_mask (circ_mask),
    .circ_base (circ_base)
);

// File: tb/dag_addr_gen_tb.sv
`timescale 1ns/1ps
module dag_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [15:0] ld_base = '0;
    logic [15:0] ld_ptr = '0;
    logic [3:0]  ld_size = '0;
    logic [1:0]  mode = '0;
    logic [7:0]  step = '0;
    logic        next = 1'b0;
    logic [15:0] addr_out;
    logic        addr_vld;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    logic [15:0] m_base, m_ptr;
    int          m_size;

    always #2 clk = ~clk;

    dag_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_base(ld_base),
        .ld_ptr(ld_ptr), .ld_size(ld_size), .mode(mode), .step(step),
        .next(next), .addr_out(addr_out), .addr_vld(addr_vld)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] b, input logic [15:0] p, input logic [3:0] s, input bit nx);
        @(negedge clk);
        ld_en = 1'b1; ld_base = b; ld_ptr = p; ld_size = s; next = nx;
        m_base = b; m_ptr = p; m_size = (s > 8) ? 8 : int'(s);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ld_en = 1'b0; next = 1'b0;
        end
    endtask

    task automatic issue(input logic [1:0] md, input logic [7:0] s, input logic [15:0] dptr, input string tag);
        logic [15:0] e;
        int          len, k, idx, rv;
        @(negedge clk);
        ld_en = 1'b0; next = 1'b1; mode = md; step = s; ld_ptr = dptr;
        case (md)
            2'b00: e = m_ptr;
            2'b01: begin
                len = 1 << m_size;
                e = 16'((int'(m_base) / len) * len + (int'(m_ptr) % len));
            end
            2'b10: begin
                k = (m_size < 3) ? 3 : m_size;
                len = 1 << k;
                idx = int'(m_ptr) % len;
                rv = 0;
                for (int b = 0; b < k; b++) if (idx[b]) rv += 1 << (k - 1 - b);
                e = 16'((int'(m_base) / len) * len + rv);
            end
            default: e = dptr;
        endcase
        if (md == 2'b11) m_ptr = dptr;
        else m_ptr = m_ptr + {{8{s[7]}}, s};
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: one expected address per valid, one cycle after the request.
    always @(negedge clk) begin
        if (rst_n && !done && addr_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected valid", addr_out, 16'h0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(addr_out == e, t, addr_out, e);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_base = '0; m_ptr = '0; m_size = 0;
        #9;
        check(addr_out == 16'h0, "R1 addr in reset", addr_out, 16'h0);
        check(addr_vld == 1'b0, "R1 valid in reset", {15'h0, addr_vld}, 16'h0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(addr_out == 16'h0, "R1 addr after reset", addr_out, 16'h0);
        check(addr_vld == 1'b0, "R1 valid after reset", {15'h0, addr_vld}, 16'h0);

        // R4 linear, positive then negative step, back to back
        load(16'h0000, 16'h1000, 4'd0, 1'b0);
        for (int i = 0; i < 5; i++) issue(2'b00, 8'd4, 16'h0, "R4 linear +4");
        for (int i = 0; i < 3; i++) issue(2'b00, 8'hFE, 16'h0, "R4 linear -2");
        idle(2);

        // R5 circular length 8, unaligned base, 24 requests (indices 8,16,15,23)
        load(16'h0105, 16'h0000, 4'd3, 1'b0);
        for (int i = 0; i < 24; i++) issue(2'b01, 8'd1, 16'h0, "R5 circular step 1");
        // R8 negative and large steps
        for (int i = 0; i < 6; i++) issue(2'b01, 8'hFD, 16'h0, "R8 circular step -3");
        for (int i = 0; i < 6; i++) issue(2'b01, 8'd5, 16'h0, "R8 circular step 5");
        idle(2);

        // R6 bit-reversed, 3 bits: 0,4,2,6,1,5,3,7
        load(16'h0040, 16'h0000, 4'd3, 1'b0);
        for (int i = 0; i < 8; i++) issue(2'b10, 8'd1, 16'h0, "R6 bitrev 3 bits");
        load(16'h0A00, 16'h0000, 4'd4, 1'b0);
        for (int i = 0; i < 8; i++) issue(2'b10, 8'd2, 16'h0, "R6 bitrev 4 bits step 2");
        load(16'h0080, 16'h0000, 4'd1, 1'b0);
        for (int i = 0; i < 8; i++) issue(2'b10, 8'd1, 16'h0, "R6 bitrev size clamp to 3");
        idle(2);

        // R7 direct then linear continues from the loaded pointer
        issue(2'b11, 8'd1, 16'h2222, "R7 direct address");
        issue(2'b00, 8'd1, 16'h0, "R7 pointer after direct");
        issue(2'b00, 8'd1, 16'h0, "R7 pointer after direct");
        idle(2);

        // R3 load wins over simultaneous next; size 12 saturates to 8
        load(16'h3000, 16'h01FF, 4'd12, 1'b1);
        idle(2);
        issue(2'b01, 8'd1, 16'h0, "R3 circular length 256 after load");
        issue(2'b01, 8'd1, 16'h0, "R3 circular wrap at 256");
        load(16'h0000, 16'h0500, 4'd0, 1'b1);
        issue(2'b00, 8'd1, 16'h0, "R3 pointer from load, next ignored");
        idle(4);

        check(exp_q.size() == 0, "R2 all requests answered", 16'(exp_q.size()), 16'h0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule